// File: doc/BRIEF.md
# JTAG Chain Identification Scanner

This block finds out which devices sit on a JTAG scan chain by reading their identification words. One pulse on `start` begins a fixed walk of the chain's TAP controllers. The block first forces every TAP into Test-Logic-Reset. It then steps them into Shift-DR and clocks out up to `MAX_DEV` 32-bit words, driving TDI high throughout. A final forced reset returns the chain to Test-Logic-Reset. After a reset every TAP has its identification register selected, so each word shifted out of the chain belongs to one device. Bits shifted past the end of the chain arrive as the ones that were fed into TDI.

Each word that is not all zeros and not all ones is stored in a small result array, in the order it was discovered. A count output says how many slots hold valid words. A one-cycle `done` pulse marks the end of the scan. TCK is derived from the system clock by a programmable divider. TMS and TDI change only while TCK is low, and TDO is sampled as TCK rises.

Top module: `jscan_id_scanner`

## Requirements
- R1: Out of reset, tck is low, tms is high, tdi is low, done is low and id_count is 0.
- R2: After start, the first 6 TCK rising edges all see TMS high.
- R3: The next 4 TCK rising edges see TMS = 0, 1, 0, 0, which moves the TAP from Test-Logic-Reset into Shift-DR.
- R4: The scan then gives exactly 32*MAX_DEV TCK rising edges in Shift-DR, and TDI is high at every one of them.
- R5: During the reads, TMS is high only on the last bit of read MAX_DEV-1. Earlier reads stay in Shift-DR, so the TAP passes through Exit1-DR exactly once.
- R6: Each word is assembled least significant bit first: the first bit received from TDO becomes bit 0.
- R7: A word equal to 32'h00000000 or 32'hFFFFFFFF is discarded. Every other value is stored.
- R8: Stored words fill slots in discovery order. Slot i sits at id_words[32*i+31:32*i], and id_count gives the number of filled slots, at most MAX_DEV.
- R9: After the exit, 6 more TCK rising edges see TMS high, leaving the TAP in Test-Logic-Reset. A whole scan is 144 rising edges when MAX_DEV is 4.
- R10: done is high for exactly one clk cycle, after the last TCK falling edge of the scan. tck stays low while the block is idle.
- R11: start clears id_count. A start that arrives while a scan is running is ignored and does not disturb that scan.
- R12: TMS and TDI change only while TCK is low, never during a TCK high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that begins a scan |
| tdo | input | 1 | Serial data returned from the chain |
| tck | output | 1 | Test clock to the chain |
| tms | output | 1 | Test mode select to the chain |
| tdi | output | 1 | Serial data into the chain |
| done | output | 1 | One-cycle pulse at the end of a scan |
| id_count | output | $clog2(MAX_DEV+1) | Number of valid stored words |
| id_words | output | 32*MAX_DEV | Stored identification words, slot 0 in the low bits |

## Verification
The bench uses a behavioural TAP model with a chain of configurable length. It records the TMS value at every TCK rise and compares the whole trace bit for bit. A design that left Shift-DR between reads, or that exited on the wrong bit, would show a different trace and a second Exit1-DR visit. Single-bit identification values at opposite ends of the word catch any bit-order error. Chains shorter than MAX_DEV return the all-ones fill, and one chain returns all zeros, which catches a filter that stores either value. A value one bit away from all ones catches a filter that is too broad. A start pulse in the middle of a scan would restart the sequence if it were not ignored, and the rise count would then exceed 144.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RST1  = 3'd1,
        PH_NAV   = 3'd2,
        PH_SHIFT = 3'd3,
        PH_RST2  = 3'd4,
        PH_DRAIN = 3'd5
    } jscan_phase_e;

    localparam int unsigned JSCAN_WORD_BITS   = 32;
    localparam int unsigned JSCAN_RESET_TICKS = 6;
    localparam int unsigned JSCAN_NAV_TICKS   = 4;

endpackage

// File: rtl/jscan_tck_gen.sv
module jscan_tck_gen #(
    parameter int unsigned HALF_PERIOD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise_now,
    output logic fall_now
);
    localparam int unsigned CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

    logic [CW-1:0] cnt_q;
    logic          tck_q;
    logic          wrap;

    assign wrap     = run && (cnt_q == CW'(HALF_PERIOD - 1));
    assign rise_now = wrap && !tck_q;
    assign fall_now = wrap && tck_q;
    assign tck      = tck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tck_q <= ~tck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/jscan_idstore.sv
module jscan_idstore #(
    parameter int unsigned MAX_DEV = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           wr,
    input  logic [31:0]                    wdata,
    output logic [$clog2(MAX_DEV+1)-1:0]   count,
    output logic [MAX_DEV*32-1:0]          slots
);
    localparam int unsigned CNT_W = $clog2(MAX_DEV + 1);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      count_q <= '0;
        else if (clr)                                    count_q <= '0;
        else if (wr && (count_q < CNT_W'(MAX_DEV)))      count_q <= count_q + 1'b1;
    end

    assign count = count_q;

    for (genvar g = 0; g < MAX_DEV; g++) begin : g_slot
        logic [31:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               word_q <= '0;
            else if (wr && (count_q == CNT_W'(g)))    word_q <= wdata;
        end
        assign slots[g*32 +: 32] = word_q;
    end
endmodule

// File: rtl/jscan_id_scanner.sv
module jscan_id_scanner
    import jscan_pkg::*;
#(
    parameter int unsigned MAX_DEV     = 4,
    parameter int unsigned HALF_PERIOD = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         tdo,
    output logic                         tck,
    output logic                         tms,
    output logic                         tdi,
    output logic                         done,
    output logic [$clog2(MAX_DEV+1)-1:0] id_count,
    output logic [MAX_DEV*32-1:0]        id_words
);
    localparam int unsigned DEV_W  = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1;
    localparam int unsigned STEP_W = 5;
    localparam logic [STEP_W-1:0] LAST_BIT = STEP_W'(JSCAN_WORD_BITS - 1);
    localparam logic [STEP_W-1:0] LAST_RST = STEP_W'(JSCAN_RESET_TICKS - 1);
    localparam logic [STEP_W-1:0] LAST_NAV = STEP_W'(JSCAN_NAV_TICKS - 1);
    localparam logic [DEV_W-1:0]  LAST_DEV = DEV_W'(MAX_DEV - 1);

    typedef struct packed {
        jscan_phase_e      phase;
        logic [STEP_W-1:0] step;
        logic [DEV_W-1:0]  dev;
        logic [31:0]       shreg;
        logic              tms;
        logic              tdi;
        logic              done;
    } scan_state_t;

    scan_state_t  st_d, st_q;
    logic         run, rise_now, fall_now;
    logic         wr, clr;
    logic [31:0]  wdata, word;
    jscan_phase_e phase_q;

    assign run     = (st_q.phase != PH_IDLE);
    assign phase_q = st_q.phase;

    jscan_tck_gen #(.HALF_PERIOD(HALF_PERIOD)) u_tck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tck      (tck),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    jscan_idstore #(.MAX_DEV(MAX_DEV)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .wr    (wr),
        .wdata (wdata),
        .count (id_count),
        .slots (id_words)
    );

    // TMS level the chain must see on the next TCK rise for a given position
    function automatic logic tms_for(jscan_phase_e p, logic [STEP_W-1:0] s,
                                     logic [DEV_W-1:0] d);
        case (p)
            PH_NAV:   return (s == STEP_W'(1));
            PH_SHIFT: return (d == LAST_DEV) && (s == LAST_BIT);
            default:  return 1'b1;
        endcase
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        wr        = 1'b0;
        clr       = 1'b0;
        word      = {tdo, st_q.shreg[31:1]};
        wdata     = word;

        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_RST1;
                    st_d.step  = '0;
                    st_d.tms   = 1'b1;
                    st_d.tdi   = 1'b0;
                    clr        = 1'b1;
                end
            end
            PH_RST1: begin
                if (rise_now) begin
                    if (st_q.step == LAST_RST) begin
                        st_d.phase = PH_NAV;
                        st_d.step  = '0;
                    end else begin
                        st_d.step = st_q.step + 1'b1;
                    end
                end
            end
            PH_NAV: begin
                if (rise_now) begin
                    if (st_q.step == LAST_NAV) begin
                        st_d.phase = PH_SHIFT;
                        st_d.step  = '0;
                        st_d.dev   = '0;
                    end else begin
                        st_d.step = st_q.step + 1'b1;
                    end
                end
            end
            PH_SHIFT: begin
                if (rise_now) begin
                    st_d.shreg = word;
                    if (st_q.step == LAST_BIT) begin
                        wr        = (word != 32'h0) && (word != 32'hFFFF_FFFF);
                        st_d.step = '0;
                        if (st_q.dev == LAST_DEV) st_d.phase = PH_RST2;
                        else                      st_d.dev   = st_q.dev + 1'b1;
                    end else begin
                        st_d.step = st_q.step + 1'b1;
                    end
                end
            end
            PH_RST2: begin
                if (rise_now) begin
                    if (st_q.step == LAST_RST) st_d.phase = PH_DRAIN;
                    else                       st_d.step  = st_q.step + 1'b1;
                end
            end
            PH_DRAIN: begin
                if (fall_now) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase

        // pins move only on the falling edge, for the position just reached
        if (fall_now) begin
            st_d.tms = tms_for(st_d.phase, st_d.step, st_d.dev);
            st_d.tdi = (st_d.phase == PH_SHIFT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.step  <= '0;
            st_q.dev   <= '0;
            st_q.shreg <= '0;
            st_q.tms   <= 1'b1;
            st_q.tdi   <= 1'b0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tms  = st_q.tms;
    assign tdi  = st_q.tdi;
    assign done = st_q.done;
endmodule

// File: rtl/jscan_checker.sv
module jscan_checker
    import jscan_pkg::*;
#(
    parameter int unsigned MAX_DEV = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tck,
    input logic                         tms,
    input logic                         tdi,
    input logic                         done,
    input logic [$clog2(MAX_DEV+1)-1:0] id_count,
    input jscan_phase_e                 phase
);
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_tck_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !tck);

    assert_reset_tms_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RST1 || phase == PH_RST2 || phase == PH_DRAIN) |-> tms);

    assert_shift_tdi_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SHIFT && !tck) |-> tdi);

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        id_count <= ($clog2(MAX_DEV+1))'(MAX_DEV));

    assert_pins_hold_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> ($stable(tms) && $stable(tdi)));
endmodule

bind jscan_id_scanner jscan_checker #(.MAX_DEV(MAX_DEV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tck      (tck),
    .tms      (tms),
    .tdi      (tdi),
    .done     (done),
    .id_count (id_count),
    .phase    (phase_q)
);

// File: tb/sim_jscan_id_scanner.sv
`timescale 1ns/1ps
module sim_jscan_id_scanner;
    localparam int MAX_DEV = 4;
    localparam int NV      = 5;
    localparam int NRISE   = 6 + 4 + 32*MAX_DEV + 6;

    // TAP state codes for the bench model
    localparam int S_TLR = 0, S_RTI = 1, S_SELDR = 2, S_CAPDR = 3, S_SHDR = 4,
                   S_EX1DR = 5, S_PDR = 6, S_EX2DR = 7, S_UPDR = 8, S_SELIR = 9,
                   S_CAPIR = 10, S_SHIR = 11, S_EX1IR = 12, S_PIR = 13,
                   S_EX2IR = 14, S_UPIR = 15;

    // stimulus: chain length, words (device 0 low), expected count and slots
    localparam int          V_LEN [NV] = '{4, 4, 2, 4, 1};
    localparam logic [127:0] V_IDS [NV] = '{
        {32'h8765_4321, 32'h1000_0001, 32'h4BA0_0477, 32'h0362_D093},
        {32'h1357_9BDF, 32'hFFFF_FFFF, 32'h2468_ACE1, 32'h0000_0000},
        {64'h0,         32'h8000_0000, 32'h0000_0001},
        {128'h0},
        {96'h0,         32'hFFFF_FFFE}};
    localparam int          V_CNT [NV] = '{4, 2, 2, 0, 1};
    localparam logic [127:0] V_EXP [NV] = '{
        {32'h8765_4321, 32'h1000_0001, 32'h4BA0_0477, 32'h0362_D093},
        {64'h0,         32'h1357_9BDF, 32'h2468_ACE1},
        {64'h0,         32'h8000_0000, 32'h0000_0001},
        {128'h0},
        {96'h0,         32'hFFFF_FFFE}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic tdo = 1'b0;
    logic tck, tms, tdi, done;
    logic [$clog2(MAX_DEV+1)-1:0] id_count;
    logic [MAX_DEV*32-1:0] id_words;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    jscan_id_scanner #(.MAX_DEV(MAX_DEV), .HALF_PERIOD(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tdo(tdo), .tck(tck),
        .tms(tms), .tdi(tdi), .done(done), .id_count(id_count), .id_words(id_words)
    );

    // ---------------- behavioural chain model ----------------
    int           tap = S_RTI;
    int           chain_len = 4;
    logic [127:0] chain_ids = '0;
    logic [127:0] chain = '0;
    logic [255:0] hist = '0;
    int           nrise = 0;
    int           shift_rises = 0;
    int           tdi_low = 0;
    int           exit1_visits = 0;

    function automatic int tap_next(int s, logic m);
        case (s)
            S_TLR:   return m ? S_TLR   : S_RTI;
            S_RTI:   return m ? S_SELDR : S_RTI;
            S_SELDR: return m ? S_SELIR : S_CAPDR;
            S_CAPDR: return m ? S_EX1DR : S_SHDR;
            S_SHDR:  return m ? S_EX1DR : S_SHDR;
            S_EX1DR: return m ? S_UPDR  : S_PDR;
            S_PDR:   return m ? S_EX2DR : S_PDR;
            S_EX2DR: return m ? S_UPDR  : S_SHDR;
            S_UPDR:  return m ? S_SELDR : S_RTI;
            S_SELIR: return m ? S_TLR   : S_CAPIR;
            S_CAPIR: return m ? S_EX1IR : S_SHIR;
            S_SHIR:  return m ? S_EX1IR : S_SHIR;
            S_EX1IR: return m ? S_UPIR  : S_PIR;
            S_PIR:   return m ? S_EX2IR : S_PIR;
            S_EX2IR: return m ? S_UPIR  : S_SHIR;
            default: return m ? S_SELDR : S_RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        if (nrise < 256) hist[nrise] = tms;
        nrise = nrise + 1;
        if (tap == S_CAPDR) begin
            chain <= chain_ids & ((128'h1 << (chain_len*32)) - 128'h1);
        end else if (tap == S_SHDR) begin
            shift_rises = shift_rises + 1;
            if (!tdi) tdi_low = tdi_low + 1;
            chain <= chain >> 1;
            chain[chain_len*32-1] <= tdi;
        end
        if (tap_next(tap, tms) == S_EX1DR) exit1_visits = exit1_visits + 1;
        tap = tap_next(tap, tms);
    end

    always @(negedge tck) tdo <= (tap == S_SHDR) ? chain[0] : 1'b0;

    // ---------------- checking ----------------
    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_trace();
        logic [255:0] t = '0;
        for (int i = 0; i < 6; i++) t[i] = 1'b1;                 // first reset
        t[7] = 1'b1;                                              // 0,1,0,0 to Shift-DR
        t[10 + 32*MAX_DEV - 1] = 1'b1;                            // exit on last bit
        for (int i = 0; i < 6; i++) t[10 + 32*MAX_DEV + i] = 1'b1; // final reset
        return t;
    endfunction

    task automatic run_scan(int v, bit glitch);
        int cyc;
        chain_len   = V_LEN[v];
        chain_ids   = V_IDS[v];
        hist        = '0;
        nrise       = 0;
        shift_rises = 0;
        tdi_low     = 0;
        exit1_visits = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk($sformatf("R11 count cleared by start (vec %0d)", v), 128'(id_count), 128'(0));
        cyc = 0;
        while (!done) begin
            @(negedge clk);
            start = glitch && (cyc == 200);
            cyc++;
        end
        start = 1'b0;
        chk($sformatf("R7 R8 count (vec %0d)", v), 128'(id_count), 128'(V_CNT[v]));
        for (int i = 0; i < V_CNT[v]; i++)
            chk($sformatf("R6 R8 slot %0d (vec %0d)", i, v),
                128'(id_words[i*32 +: 32]), 128'(V_EXP[v][i*32 +: 32]));
        chk($sformatf("R2 R3 R5 R9 TMS trace (vec %0d)", v), 128'(nrise), 128'(NRISE));
        chk($sformatf("R2 R3 R5 R9 TMS bits (vec %0d)", v),
            hist[127:0], exp_trace() >> 0);
        chk($sformatf("R5 R9 TMS bits high (vec %0d)", v),
            {hist[255:128]}, exp_trace() >> 128);
        chk($sformatf("R4 shift length (vec %0d)", v), 128'(shift_rises), 128'(32*MAX_DEV));
        chk($sformatf("R4 tdi low in shift (vec %0d)", v), 128'(tdi_low), 128'(0));
        chk($sformatf("R5 Exit1-DR visits (vec %0d)", v), 128'(exit1_visits), 128'(1));
        chk($sformatf("R9 TAP ends in reset (vec %0d)", v), 128'(tap), 128'(S_TLR));
        chk($sformatf("R10 tck low at done (vec %0d)", v), 128'(tck), 128'(0));
        @(negedge clk);
        chk($sformatf("R10 done one cycle (vec %0d)", v), 128'(done), 128'(0));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 tck", 128'(tck), 128'(0));
        chk("R1 tms", 128'(tms), 128'(1));
        chk("R1 tdi", 128'(tdi), 128'(0));
        chk("R1 done", 128'(done), 128'(0));
        chk("R1 count", 128'(id_count), 128'(0));
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 tck idle", 128'(tck), 128'(0));

        // table walk; vector 1 also gets a start strobe mid-scan (R11 ignored)
        for (int v = 0; v < NV; v++) begin
            run_scan(v, v == 1);
            repeat (4) @(negedge clk);
        end

        // R12: pins must not have moved during any high phase (checked on the fly)
        begin
            logic ptms, ptdi;
            int moved = 0;
            chain_len = 4; chain_ids = V_IDS[0];
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            while (!done) begin
                ptms = tms; ptdi = tdi;
                @(negedge clk);
                if (tck && ((tms !== ptms) || (tdi !== ptdi)) && ($time > 0)) begin
                    // only a change that lands while tck stays high is a violation
                    moved++;
                end
            end
            chk("R12 pins stable while tck high", 128'(moved), 128'(0));
            chk("R8 repeat scan count", 128'(id_count), 128'(4));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule